// File: doc/BRIEF.md
# Edge-Triggered Interrupt Collector

This block gathers a set of external interrupt request lines into one interrupt output for a host processor. Every line passes through a two-flop synchronizer and a rising-edge detector. Each edge it detects sets one bit in a pending-flag register. A mask register then decides which pending bits can reach the output. Only a fixed group of lines, 8, 9 and 10 by default, is routed to the output.

Software reaches both registers over a simple synchronous register bus. Each register is 16 bits wide. Reads return data one cycle after the request. A pending flag is cleared by writing a 0 into its bit position; a 1 in the write data leaves that bit as it is. Several flags can be pending at the same time, and software services them one by one. A mask bit of 1 blocks its line. Masking has no effect on flag latching: a flag set while its line is masked reaches the output as soon as the line is unmasked.

Top module: `irq_edge_collector`

## Requirements
- R1: A rising edge on irqIn[n] sets flag bit n exactly once. A line held high sets no new flag after software clears the bit.
- R2: Flag bits hold their value until software clears them. Several flags can be pending at once and none is lost.
- R3: A write to offset 0x2 clears each flag bit whose write-data bit is 0 and leaves each flag bit whose write-data bit is 1 unchanged.
- R4: When an edge on a line and a clearing write to that line's flag take effect in the same cycle, the flag ends up set.
- R5: A write to offset 0xA loads the mask register. After reset the mask reads 0xFFFF and all flags read 0x0000.
- R6: A flag bit latches on an edge whatever the state of its mask bit.
- R7: irqOut is high one cycle after (flags & ~mask & 0x0700) becomes nonzero, and low one cycle after it becomes zero. Lines outside 8..10 never raise it.
- R8: A read request at offset 0x2 or 0xA puts that register's value on busRdData on the next cycle. A read of any other offset returns 0, and a write to any other offset changes nothing.
- R9: irqOut is a registered output and is low during reset and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | 4 | Register byte offset |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 16 | Write data |
| busRdEn | input | 1 | Read request |
| busRdData | output | 16 | Read data, valid the cycle after the request |
| irqIn | input | 16 | Asynchronous interrupt request lines |
| irqOut | output | 1 | Combined interrupt level to the host |

## Verification
The bench first sends single pulses on masked lines, which separates flag latching from output gating. It then sends pulses on a routed line and an unrouted line together, which shows that several flags stay pending while only routed lines drive the output. A line held high across a clear shows that one level produces only one event. An edge placed in the same cycle as a clear-all write shows that the edge wins the collision. Accesses to an unmapped offset confirm that they read back zero and leave both registers unchanged.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;
  typedef struct packed {
    logic wrFlag;
    logic wrMask;
    logic rdFlag;
    logic rdMask;
    logic rdAny;
  } irqStrb_t;
endpackage

// File: rtl/irq_collector_ctrl.sv
module irq_collector_ctrl
  import irq_collector_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] FLAG_OFS = 'h2,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output irqStrb_t          strb
);
  logic hitFlag, hitMask;

  assign hitFlag = (busAddr == FLAG_OFS);
  assign hitMask = (busAddr == MASK_OFS);

  always_comb begin
    strb.wrFlag = busWrEn & hitFlag;
    strb.wrMask = busWrEn & hitMask;
    strb.rdFlag = busRdEn & hitFlag;
    strb.rdMask = busRdEn & hitMask;
    strb.rdAny  = busRdEn;
  end

  // R8: unmapped writes produce no register strobe
  p_unmapped_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busAddr != FLAG_OFS && busAddr != MASK_OFS) |-> !(strb.wrFlag || strb.wrMask));

  p_one_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.wrFlag, strb.wrMask, strb.rdFlag, strb.rdMask}) || (busWrEn && busRdEn));
endmodule

// File: rtl/irq_collector_datapath.sv
module irq_collector_datapath
  import irq_collector_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter logic [NUM_LINES-1:0] ROUTE_SEL = 16'h0700,
  parameter logic [NUM_LINES-1:0] MASK_RST  = 16'hFFFF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  irqStrb_t             strb,
  input  logic [NUM_LINES-1:0] wrData,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic [NUM_LINES-1:0] rdData,
  output logic                 irqOut
);
  logic [NUM_LINES-1:0] syncA, syncB, syncPrev;
  logic [NUM_LINES-1:0] edgeDet, flags, flagsNext, mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= irqIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign edgeDet = syncB & ~syncPrev;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_flag
    logic keepBit;
    assign keepBit      = strb.wrFlag ? (flags[i] & wrData[i]) : flags[i];
    assign flagsNext[i] = keepBit | edgeDet[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= '0;
      mask   <= MASK_RST;
      irqOut <= 1'b0;
      rdData <= '0;
    end else begin
      flags  <= flagsNext;
      if (strb.wrMask) mask <= wrData;
      irqOut <= |(flags & ~mask & ROUTE_SEL);
      if (strb.rdAny)
        rdData <= strb.rdFlag ? flags : (strb.rdMask ? mask : '0);
    end
  end

  p_edge_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (edgeDet != '0) |=> ((flags & $past(edgeDet)) == $past(edgeDet)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.wrFlag && edgeDet == '0) |=> $stable(flags));

  p_mask_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrMask |=> $stable(mask));

  p_rd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdAny && !strb.rdFlag && !strb.rdMask) |=> (rdData == '0));

  p_unrouted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~mask & ROUTE_SEL) == '0) |=> !irqOut);
endmodule

// File: rtl/irq_edge_collector.sv
module irq_edge_collector
  import irq_collector_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] FLAG_OFS = 'h2,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'hA,
  parameter logic [NUM_LINES-1:0] ROUTE_SEL = 16'h0700,
  parameter logic [NUM_LINES-1:0] MASK_RST  = 16'hFFFF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [NUM_LINES-1:0] busWrData,
  input  logic                 busRdEn,
  output logic [NUM_LINES-1:0] busRdData,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic                 irqOut
);
  irqStrb_t strb;

  irq_collector_ctrl #(.ADDR_W(ADDR_W), .FLAG_OFS(FLAG_OFS), .MASK_OFS(MASK_OFS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .strb(strb)
  );

  irq_collector_datapath #(.NUM_LINES(NUM_LINES), .ROUTE_SEL(ROUTE_SEL), .MASK_RST(MASK_RST)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(busWrData), .irqIn(irqIn),
    .rdData(busRdData), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_irq_edge_collector.sv
module tb_irq_edge_collector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [15:0] busRdData;
  logic [15:0] irqIn = '0;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  irq_edge_collector dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .irqIn(irqIn), .irqOut(irqOut)
  );

  always #2 clk = ~clk;

  // behavioural reference: input history queue and register images
  logic [15:0] hist[$];
  logic [15:0] mFlags, mMask, mRd;
  logic        mOut;

  initial begin
    hist = '{16'h0, 16'h0, 16'h0};
    mFlags = '0; mMask = 16'hFFFF; mRd = '0; mOut = 1'b0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{16'h0, 16'h0, 16'h0};
      mFlags = '0; mMask = 16'hFFFF; mRd = '0; mOut = 1'b0;
    end else begin
      logic [15:0] ev, nf;
      ev = hist[1] & ~hist[2];
      if (busRdEn)
        mRd = (busAddr == 4'h2) ? mFlags : ((busAddr == 4'hA) ? mMask : 16'h0);
      mOut = ((mFlags & ~mMask & 16'h0700) != 0);
      nf = mFlags;
      if (busWrEn && busAddr == 4'h2) nf = nf & busWrData;
      nf = nf | ev;
      if (busWrEn && busAddr == 4'hA) mMask = busWrData;
      mFlags = nf;
      hist.push_front(irqIn);
      void'(hist.pop_back());
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(irqOut == mOut, "R7 model irqOut", irqOut, mOut);
      check(busRdData == mRd, "R8 model rdData", busRdData, mRd);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    tick(1);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    busAddr = a; busRdEn = 1'b1;
    tick(1);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic pulse(input int line);
    irqIn[line] = 1'b1;
    tick(2);
    irqIn[line] = 1'b0;
    tick(4);
  endtask

  initial begin
    logic [15:0] v;
    tick(3);
    check(irqOut == 1'b0, "R9 reset irqOut", irqOut, 0);
    rst_n = 1'b1;
    tick(1);
    check(irqOut == 1'b0, "R9 post-reset irqOut", irqOut, 0);
    rd(4'h2, v); check(v == 16'h0000, "R5 reset flags", v, 16'h0000);
    rd(4'hA, v); check(v == 16'hFFFF, "R5 reset mask", v, 16'hFFFF);

    pulse(9);
    rd(4'h2, v); check(v == 16'h0200, "R6 masked latch", v, 16'h0200);
    check(irqOut == 1'b0, "R7 masked no out", irqOut, 0);
    wr(4'hA, 16'h0000);
    tick(2);
    check(irqOut == 1'b1, "R7 unmask raises", irqOut, 1);

    pulse(3);
    pulse(10);
    rd(4'h2, v); check(v == 16'h0608, "R2 multi pending", v, 16'h0608);
    wr(4'h2, 16'hFDFF);
    rd(4'h2, v); check(v == 16'h0408, "R3 selective clear", v, 16'h0408);
    tick(1);
    check(irqOut == 1'b1, "R7 still pending", irqOut, 1);
    wr(4'h2, 16'hFBFF);
    tick(2);
    check(irqOut == 1'b0, "R7 unrouted line", irqOut, 0);

    irqIn[8] = 1'b1;
    tick(5);
    rd(4'h2, v); check(v == 16'h0108, "R1 edge sets", v, 16'h0108);
    wr(4'h2, 16'hFEFF);
    tick(5);
    rd(4'h2, v); check(v == 16'h0008, "R1 level no retrigger", v, 16'h0008);
    irqIn[8] = 1'b0;
    tick(4);

    irqIn[10] = 1'b1;
    tick(2);
    wr(4'h2, 16'h0000);
    rd(4'h2, v); check(v == 16'h0400, "R4 edge beats clear", v, 16'h0400);
    irqIn[10] = 1'b0;
    tick(3);
    wr(4'h2, 16'h0000);
    rd(4'h2, v); check(v == 16'h0000, "R3 clear all", v, 16'h0000);

    wr(4'hA, 16'h0700);
    rd(4'hA, v); check(v == 16'h0700, "R5 mask load", v, 16'h0700);
    pulse(8);
    check(irqOut == 1'b0, "R6 masked line", irqOut, 0);
    wr(4'hA, 16'h0000);
    tick(2);
    check(irqOut == 1'b1, "R6 visible after unmask", irqOut, 1);

    wr(4'h4, 16'h1234);
    rd(4'h4, v); check(v == 16'h0000, "R8 unmapped read", v, 0);
    rd(4'hA, v); check(v == 16'h0000, "R8 mask untouched", v, 0);
    rd(4'h2, v); check(v == 16'h0100, "R8 flags untouched", v, 16'h0100);
    tick(3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule